// File: doc/BRIEF.md
# Panel Backlight PWM Controller

This block sits on the panel side of a display link and turns a few host-programmed byte registers into a backlight PWM waveform. The host reaches the registers over a plain strobe bus. There is a write strobe, a read strobe, a 16-bit byte address and a continuation flag. When the flag is set on an access, the access goes to the address after the previous access. This lets the two brightness bytes travel as one burst.

The PWM runs directly from the block clock, which is the fixed base clock. One period lasts F × 2^Pn base clocks. F is an 8-bit pre-divider and Pn is a bit count. In the register-controlled mode, the brightness level sets the number of high slots in each period. The level is clamped to the largest value the bit count allows. In every other mode the output is held fully on. A display-control enable bit gates the output. New timing and brightness values are picked up only at a period boundary.

Top module: `bl_pwm_ctrl`

## Requirements
- R1: After reset, `pwm_out` is 0. The registers read back as: display control 0x00, mode 0x00, brightness high 0x00, brightness low 0x00, bit count 0x08, pre-divider 0x00.
- R2: One PWM period lasts Fe × 2^Pn clocks. Fe is the pre-divider register (address 0x728) when bit 7 of the mode register (address 0x721) is 1. Otherwise Fe is the parameter `DEF_DIV` (default 2).
- R3: When frequency override is active, a pre-divider value of 0 acts as 1.
- R4: In register-controlled mode (mode bits 1:0 = 2'b10), `pwm_out` is high for min(level, 2^Pn − 1) × Fe clocks of each period.
- R5: With `wide_cap` = 1, the level is {high byte at 0x722, low byte at 0x723}. With `wide_cap` = 0, the level is the high byte alone.
- R6: In any mode other than 2'b10, `pwm_out` is high on every clock while it is enabled.
- R7: Bit 0 of the display-control register (address 0x720) gates `pwm_out`. When it is 0, the output is 0 from the next clock onward. Every bit written to that register is kept and reads back.
- R8: The active level, Fe and Pn change only at the end of a PWM period. Until then, the period in progress finishes with the old values.
- R9: An access with `burst` = 1 uses the previous access address plus one. This applies to both reads and writes, and `addr` is ignored on that access.
- R10: A write to an address not in the map has no effect. A read of such an address returns 0x00.
- R11: The bit-count register (address 0x724) keeps bits 4:0 and reads back 0 in bits 7:5. A Pn above `MAX_PN` acts as `MAX_PN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; also the PWM time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| burst | input | 1 | Use previous address + 1 instead of `addr` |
| addr | input | AW (16) | Byte address |
| wdata | input | 8 | Write data |
| wide_cap | input | 1 | Selects the 16-bit brightness level |
| rdata | output | 8 | Read data (combinational, valid while `rd_en`) |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
Some properties are checked by assertions on every cycle. The active timing and level values stay unchanged anywhere except a period boundary. The pre-divider and phase counters stay inside the active F and 2^Pn. The active Pn and duty never go beyond their limits. A write that clears the enable bit silences the output on the next clock. Other behaviour can only be shown by the bench scenarios, which count high cycles over whole periods. These cover the duty and period under different F, Pn, mode and width settings, clamping of the level, the zero pre-divider, and burst auto-increment. The bench also checks that a brightness write made mid-period shows up only in the following period.

// File: rtl/bl_pwm_ctrl.sv
module bl_pwm_ctrl #(
  parameter int AW      = 16,
  parameter int MAX_PN  = 16,
  parameter int DEF_DIV = 2,
  parameter logic [AW-1:0] A_DISP = 16'h0720,
  parameter logic [AW-1:0] A_MODE = 16'h0721,
  parameter logic [AW-1:0] A_HI   = 16'h0722,
  parameter logic [AW-1:0] A_LO   = 16'h0723,
  parameter logic [AW-1:0] A_BITS = 16'h0724,
  parameter logic [AW-1:0] A_FDIV = 16'h0728
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          burst,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          wide_cap,
  output logic [7:0]    rdata,
  output logic          pwm_out
);
  localparam int PW = MAX_PN + 1;
  localparam int CW = (PW > 16) ? PW : 16;
  localparam logic [4:0] RST_PN = (MAX_PN < 8) ? 5'(MAX_PN) : 5'd8;
  localparam logic [1:0] MODE_REG = 2'b10;

  logic [7:0]    disp_q, mode_q, hi_q, lo_q, fdiv_q;
  logic [4:0]    bits_q;
  logic [AW-1:0] last_q, eff;

  assign eff = burst ? last_q + AW'(1) : addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= '0; mode_q <= '0; hi_q <= '0; lo_q <= '0;
      fdiv_q <= '0; bits_q <= 5'd8; last_q <= '0;
    end else begin
      if (wr_en || rd_en) last_q <= eff;
      if (wr_en) begin
        case (eff)
          A_DISP: disp_q <= wdata;
          A_MODE: mode_q <= wdata;
          A_HI:   hi_q   <= wdata;
          A_LO:   lo_q   <= wdata;
          A_BITS: bits_q <= wdata[4:0];
          A_FDIV: fdiv_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (eff)
        A_DISP: rdata = disp_q;
        A_MODE: rdata = mode_q;
        A_HI:   rdata = hi_q;
        A_LO:   rdata = lo_q;
        A_BITS: rdata = {3'b000, bits_q};
        A_FDIV: rdata = fdiv_q;
        default: rdata = '0;
      endcase
    end
  end

  logic [4:0]    pn_req;
  logic [7:0]    f_req;
  logic [15:0]   lvl;
  logic [CW-1:0] lvl_c, max_c;
  logic [PW-1:0] duty_req;

  assign pn_req = (32'(bits_q) > MAX_PN) ? 5'(MAX_PN) : bits_q;
  assign f_req  = mode_q[7] ? ((fdiv_q == 8'd0) ? 8'd1 : fdiv_q) : 8'(DEF_DIV);
  assign lvl    = wide_cap ? {hi_q, lo_q} : {8'h00, hi_q};
  assign lvl_c  = CW'(lvl);
  assign max_c  = CW'((PW'(1) << pn_req) - PW'(1));
  assign duty_req = (mode_q[1:0] != MODE_REG) ? (PW'(1) << pn_req)
                  : PW'((lvl_c > max_c) ? max_c : lvl_c);

  logic [7:0]        pc, act_f;
  logic [MAX_PN-1:0] ph;
  logic [4:0]        act_pn;
  logic [PW-1:0]     act_duty, ph_top;
  logic              slot_end, bnd;

  assign ph_top   = (PW'(1) << act_pn) - PW'(1);
  assign slot_end = (pc == 8'(act_f - 8'd1));
  assign bnd      = slot_end && ({1'b0, ph} == ph_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      ph       <= '0;
      act_f    <= 8'(DEF_DIV);
      act_pn   <= RST_PN;
      act_duty <= PW'(1) << RST_PN;
    end else if (bnd) begin
      pc       <= '0;
      ph       <= '0;
      act_f    <= f_req;
      act_pn   <= pn_req;
      act_duty <= duty_req;
    end else if (slot_end) begin
      pc <= '0;
      ph <= ph + MAX_PN'(1);
    end else begin
      pc <= pc + 8'd1;
    end
  end

  assign pwm_out = disp_q[0] && ({1'b0, ph} < act_duty);
endmodule

// File: rtl/bl_pwm_ctrl_chk.sv
module bl_pwm_ctrl_chk #(
  parameter int AW = 16,
  parameter int MAX_PN = 16,
  parameter logic [AW-1:0] A_DISP = 16'h0720
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              burst,
  input logic [AW-1:0]     addr,
  input logic [7:0]        wdata,
  input logic              pwm_out,
  input logic [7:0]        pc,
  input logic [MAX_PN-1:0] ph,
  input logic [7:0]        act_f,
  input logic [4:0]        act_pn,
  input logic [MAX_PN:0]   act_duty,
  input logic              bnd
);
  localparam int PW = MAX_PN + 1;
  logic [PW-1:0] span;
  assign span = PW'(1) << act_pn;

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !burst && addr == A_DISP && !wdata[0]) |=> !pwm_out); // R7
  AST_F_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    act_f != 8'd0); // R3
  AST_PC_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pc < act_f); // R2
  AST_PH_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ph} < span); // R2
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> ($stable(act_duty) && $stable(act_pn) && $stable(act_f))); // R8
  AST_PN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(act_pn) <= MAX_PN); // R11
  AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    act_duty <= span); // R4
endmodule

bind bl_pwm_ctrl bl_pwm_ctrl_chk #(.AW(AW), .MAX_PN(MAX_PN), .A_DISP(A_DISP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .burst(burst), .addr(addr),
  .wdata(wdata), .pwm_out(pwm_out), .pc(pc), .ph(ph), .act_f(act_f),
  .act_pn(act_pn), .act_duty(act_duty), .bnd(bnd)
);

// File: tb/tb_bl_pwm_ctrl.sv
module tb_bl_pwm_ctrl;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, burst = 0, wide_cap = 0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic pwm_out;
  int checks = 0, errors = 0;

  localparam logic [15:0] DISP = 16'h0720, MODE = 16'h0721, HI = 16'h0722,
                          LO = 16'h0723, BITS = 16'h0724, FDIV = 16'h0728;

  bl_pwm_ctrl #(.MAX_PN(6)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .burst(burst),
    .addr(addr), .wdata(wdata), .wide_cap(wide_cap), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic b);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; burst = b;
    @(negedge clk); wr_en = 0; burst = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic b, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a; burst = b;
    #1 d = rdata;
    @(negedge clk); rd_en = 0; burst = 0;
  endtask

  task automatic highs(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); h += int'(pwm_out); end
  endtask

  task automatic settle(); repeat (300) @(negedge clk); endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 pwm", int'(pwm_out), 0);
    rd(DISP, 0, d); chk("R1 disp", d, 8'h00);
    rd(MODE, 0, d); chk("R1 mode", d, 8'h00);
    rd(HI, 0, d);   chk("R1 hi", d, 8'h00);
    rd(LO, 0, d);   chk("R1 lo", d, 8'h00);
    rd(BITS, 0, d); chk("R1 bits", d, 8'h08);
    rd(FDIV, 0, d); chk("R1 fdiv", d, 8'h00);
  endtask

  task automatic t_full_duty();
    int h;
    wr(DISP, 8'h01, 0); settle(); highs(64, h); chk("R6 full duty mode0", h, 64);
    wr(MODE, 8'h03, 0); settle(); highs(64, h); chk("R6 full duty mode3", h, 64);
  endtask

  task automatic t_reg_mode();
    int h;
    wide_cap = 0;
    wr(MODE, 8'h02, 0); wr(BITS, 8'd3, 0); wr(HI, 8'd3, 0);
    settle(); highs(32, h); chk("R4 R2 default div", h, 12);
    wr(MODE, 8'h82, 0); wr(FDIV, 8'd3, 0);
    settle(); highs(48, h); chk("R2 override div3", h, 18);
    wr(FDIV, 8'd0, 0);
    settle(); highs(16, h); chk("R3 zero div", h, 6);
    wr(FDIV, 8'd1, 0); wr(HI, 8'd200, 0);
    settle(); highs(16, h); chk("R4 clamp", h, 14);
  endtask

  task automatic t_wide_burst();
    int h; logic [7:0] d;
    wide_cap = 1;
    wr(BITS, 8'd4, 0);
    wr(HI, 8'h00, 0); wr(16'h0000, 8'h05, 1);
    settle(); highs(32, h); chk("R5 R9 wide level", h, 10);
    rd(HI, 0, d); rd(16'h0000, 1, d); chk("R9 burst read", d, 8'h05);
    wide_cap = 0;
    settle(); highs(32, h); chk("R5 narrow level", h, 0);
  endtask

  task automatic t_enable();
    int h; logic [7:0] d;
    wr(DISP, 8'h81, 0); wr(MODE, 8'h00, 0);
    settle(); highs(32, h); chk("R7 enabled", h, 32);
    wr(DISP, 8'h80, 0); highs(32, h); chk("R7 disabled", h, 0);
    rd(DISP, 0, d); chk("R7 other bits kept", d, 8'h80);
  endtask

  task automatic t_unknown();
    int h; logic [7:0] d;
    wr(DISP, 8'h01, 0);
    wr(16'h0725, 8'hFF, 0); wr(16'h0000, 8'h00, 0);
    rd(16'h0725, 0, d); chk("R10 unmapped read", d, 8'h00);
    rd(MODE, 0, d); chk("R10 mode untouched", d, 8'h00);
    settle(); highs(32, h); chk("R10 output untouched", h, 32);
  endtask

  task automatic t_pn_cap();
    int h; logic [7:0] d;
    wr(BITS, 8'hFF, 0); rd(BITS, 0, d); chk("R11 bits readback", d, 8'h1F);
    wide_cap = 1;
    wr(MODE, 8'h82, 0); wr(FDIV, 8'd1, 0); wr(HI, 8'hFF, 0); wr(LO, 8'hFF, 0);
    settle(); highs(128, h); chk("R11 pn clamp", h, 126);
    wide_cap = 0;
  endtask

  task automatic t_boundary();
    int h, guard; logic prev;
    wr(BITS, 8'd3, 0); wr(HI, 8'd2, 0);
    settle();
    prev = pwm_out; guard = 0;
    while (guard < 100) begin
      @(negedge clk);
      if (pwm_out && !prev) break;
      prev = pwm_out; guard++;
    end
    wr_en = 1; addr = HI; wdata = 8'd6; burst = 0;
    h = 1;
    @(negedge clk); wr_en = 0; h += int'(pwm_out);
    repeat (6) begin @(negedge clk); h += int'(pwm_out); end
    chk("R8 old level finishes period", h, 2);
    highs(8, h); chk("R8 new level next period", h, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_full_duty();
    t_reg_mode();
    t_wide_burst();
    t_enable();
    t_unknown();
    t_pn_cap();
    t_boundary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule